// File: doc/BRIEF.md
# Multi-Mode PHY Receive Capture

This block takes the receive side of an external Ethernet PHY and turns it into one qualified stream of symbols in the core clock domain. A two-bit mode input selects how the receive pins are read. In the 4-bit mode, nibbles are paired into bytes. In the 8-bit mode, one byte is taken per clock together with its valid and error flags. In the 10-bit mode, code-groups arrive on two half-rate clocks that alternate, and they are merged back into the order in which they arrived.

In the 4-bit and 8-bit modes, the core clock `clk` must be the PHY receive clock. The clock selection is made outside this block. In the 10-bit mode, `clk` runs at 125 MHz and the two phase clocks are independent 62.5 MHz inputs. Each phase writes into its own small lane buffer. A sequencer in the core domain reads the two lanes alternately and flags any symbol it had to take out of turn. The PHY collision input is synchronized and then gated by the duplex setting and the mode.

Top module: `rx_phy_capture`

## Requirements
- R1: While `rstN` is low and just after it is released, `outValid`, `outErr`, `outDribble`, `outSlip` and `colOut` are all 0.
- R2: With mode 2'b01, each rising `clk` edge that samples `rxDv`=1 gives `outValid`=1 after that same edge, with `outData`={2'b00, rxD} and `outErr`=rxErr. An edge that samples `rxDv`=0 gives `outValid`=0, `outErr`=0 and `outData`=0.
- R3: With mode 2'b00, only `rxD[3:0]` is used. The first nibble of a pair produces no output. The edge that samples the second nibble gives `outValid`=1 with `outData[7:0]`={second nibble, first nibble} and `outData[9:8]`=0. Two consecutive cycles never both show `outValid`.
- R4: With mode 2'b00, `outErr` is 1 on a byte when `rxErr` was sampled high with either of its two nibbles.
- R5: With mode 2'b00, if `rxDv` falls while one nibble is held, the edge that samples `rxDv`=0 gives `outValid`=1, `outData`={6'b0, nibble}, `outDribble`=1, and `outErr` equal to that nibble's error.
- R6: With mode 2'b10, each phase clock captures the code-group {rxErr, rxDv, rxD[7:0]} (bits 9, 8, 7:0). Code-group 0 after reset arrives on `tbiClkEven`, and then the two phases alternate. The groups appear on `outData` in arrival order, one per `outValid` pulse, with `outSlip`=0.
- R7: With mode 2'b10, if the lane due next is empty while the other lane holds at least two groups, the oldest group of the other lane is output with `outSlip`=1, and alternation continues from that lane.
- R8: In half duplex (`fullDuplex`=0) and with a mode other than 2'b10, `colOut` follows `colIn` delayed by exactly two rising `clk` edges.
- R9: `colOut` is 0 whenever `fullDuplex`=1 or the mode is 2'b10, whatever the value of `colIn`.
- R10: Mode 2'b11 is idle: no `outValid` is produced, whatever the receive inputs do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock. In the 4-bit and 8-bit modes this is the PHY receive clock. |
| rstN | input | 1 | Asynchronous reset, active low |
| mode | input | 2 | 00 = 4-bit, 01 = 8-bit, 10 = 10-bit split-phase, 11 = idle |
| fullDuplex | input | 1 | 1 masks the collision input |
| rxD | input | 8 | Receive data; bits 7:0 of the code-group in 10-bit mode |
| rxDv | input | 1 | Receive valid; code-group bit 8 in 10-bit mode |
| rxErr | input | 1 | Receive error; code-group bit 9 in 10-bit mode |
| tbiClkEven | input | 1 | Phase clock for even-numbered code-groups |
| tbiClkOdd | input | 1 | Phase clock for odd-numbered code-groups |
| colIn | input | 1 | Asynchronous collision input from the PHY |
| outValid | output | 1 | One-cycle strobe: a symbol is present on the outputs |
| outData | output | 10 | Byte in bits 7:0, or the full code-group |
| outErr | output | 1 | Error recorded against this byte |
| outDribble | output | 1 | Partial byte from an odd nibble count |
| outSlip | output | 1 | Code-group taken out of turn |
| colOut | output | 1 | Synchronized and gated collision |

## Verification
A wrong nibble-pairing state shows up at the very next output strobe: the two halves come out swapped, a pair that should be a dribble byte arrives as a full byte, or a dribble strobe is missing one cycle after valid falls. A sequencer that points at the wrong lane shows up within the first pair of code-groups as a reordered stream or an unexpected slip flag. A stuck or mis-counted lane pointer shows up a few core cycles after the phase clocks stop, as a missing slip or a wrong replayed group. Collision gating and synchronizer depth are checked at the exact edge on which `colOut` must change.

// File: rtl/rx_capture_pkg.sv
package rx_capture_pkg;

  localparam int CG_W  = 10;
  localparam int NIB_W = 4;

  typedef enum logic [1:0] {
    MODE_NIB  = 2'b00,
    MODE_BYTE = 2'b01,
    MODE_TBI  = 2'b10,
    MODE_OFF  = 2'b11
  } rxMode_t;

  typedef struct packed {
    logic loadLow;
    logic emitPair;
    logic emitPartial;
    logic emitByte;
    logic emitTbi;
    logic tbiOdd;
    logic slip;
  } rxStrobe_t;

endpackage

// File: rtl/rx_tbi_lane.sv
module rx_tbi_lane #(
  parameter int AW   = 2,
  parameter int W    = 10,
  parameter int SYNC = 2,
  localparam int PW    = AW + 1,
  localparam int DEPTH = 1 << AW
) (
  input  logic          wrClk,
  input  logic          clk,
  input  logic          rstN,
  input  logic          wrEn,
  input  logic [W-1:0]  wrData,
  input  logic          pop,
  output logic [W-1:0]  rdData,
  output logic [PW-1:0] count
);

  logic [W-1:0]  mem [DEPTH];
  logic [PW-1:0] wrBin;
  logic [PW-1:0] wrGray;
  logic [PW-1:0] syncQ [SYNC];
  logic [PW-1:0] rdPtr;
  logic [PW-1:0] wrSeen;

  function automatic logic [PW-1:0] grayToBin(input logic [PW-1:0] g);
    logic [PW-1:0] b;
    b[PW-1] = g[PW-1];
    for (int i = PW - 2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction

  // write side, phase clock domain
  always_ff @(posedge wrClk or negedge rstN) begin
    if (!rstN) begin
      wrBin  <= '0;
      wrGray <= '0;
    end else if (wrEn) begin
      wrBin  <= wrBin + 1'b1;
      wrGray <= (wrBin + 1'b1) ^ ((wrBin + 1'b1) >> 1);
    end
  end

  always_ff @(posedge wrClk) begin
    if (wrEn) mem[wrBin[AW-1:0]] <= wrData;
  end

  // pointer crossing into the core domain
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < SYNC; i++) syncQ[i] <= '0;
    end else begin
      syncQ[0] <= wrGray;
      for (int i = 1; i < SYNC; i++) syncQ[i] <= syncQ[i-1];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)    rdPtr <= '0;
    else if (pop) rdPtr <= rdPtr + 1'b1;
  end

  assign wrSeen = grayToBin(syncQ[SYNC-1]);
  assign count  = wrSeen - rdPtr;
  assign rdData = mem[rdPtr[AW-1:0]];

endmodule

// File: rtl/rx_capture_ctrl.sv
module rx_capture_ctrl
  import rx_capture_pkg::*;
#(
  parameter int PW = 3
) (
  input  logic                clk,
  input  logic                rstN,
  input  rxMode_t             modeE,
  input  logic                rxDv,
  input  logic [1:0][PW-1:0]  laneCnt,
  output rxStrobe_t           strobe
);

  logic haveLow;
  logic expectOdd;
  logic [PW-1:0] dueCnt;
  logic [PW-1:0] otherCnt;

  assign dueCnt   = expectOdd ? laneCnt[1] : laneCnt[0];
  assign otherCnt = expectOdd ? laneCnt[0] : laneCnt[1];

  always_comb begin
    strobe = '0;
    unique case (modeE)
      MODE_NIB: begin
        if (rxDv) begin
          if (haveLow) strobe.emitPair = 1'b1;
          else         strobe.loadLow  = 1'b1;
        end else if (haveLow) begin
          strobe.emitPartial = 1'b1;
        end
      end
      MODE_BYTE: strobe.emitByte = rxDv;
      MODE_TBI: begin
        if (dueCnt != '0) begin
          strobe.emitTbi = 1'b1;
          strobe.tbiOdd  = expectOdd;
        end else if (otherCnt >= PW'(2)) begin
          strobe.emitTbi = 1'b1;
          strobe.tbiOdd  = !expectOdd;
          strobe.slip    = 1'b1;
        end
      end
      default: strobe = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      haveLow   <= 1'b0;
      expectOdd <= 1'b0;
    end else begin
      if (modeE != MODE_NIB)                       haveLow <= 1'b0;
      else if (strobe.loadLow)                     haveLow <= 1'b1;
      else if (strobe.emitPair || strobe.emitPartial) haveLow <= 1'b0;

      if (modeE != MODE_TBI)   expectOdd <= 1'b0;
      else if (strobe.emitTbi) expectOdd <= !strobe.tbiOdd;
    end
  end

endmodule

// File: rtl/rx_capture_dp.sv
module rx_capture_dp
  import rx_capture_pkg::*;
#(
  parameter int LANE_AW   = 2,
  parameter int PTR_SYNC  = 2,
  parameter int COL_SYNC  = 2,
  localparam int PW = LANE_AW + 1
) (
  input  logic                clk,
  input  logic                rstN,
  input  rxMode_t             modeE,
  input  logic                fullDuplex,
  input  logic [7:0]          rxD,
  input  logic                rxDv,
  input  logic                rxErr,
  input  logic                tbiClkEven,
  input  logic                tbiClkOdd,
  input  logic                colIn,
  input  rxStrobe_t           strobe,
  output logic [1:0][PW-1:0]  laneCnt,
  output logic                outValid,
  output logic [CG_W-1:0]     outData,
  output logic                outErr,
  output logic                outDribble,
  output logic                outSlip,
  output logic                colOut
);

  logic [1:0]             laneClk;
  logic [1:0]             lanePop;
  logic [1:0][CG_W-1:0]   laneData;
  logic [CG_W-1:0]        codeGroup;
  logic [NIB_W-1:0]       lowNib;
  logic                   lowErr;
  logic [COL_SYNC-1:0]    colQ;

  assign laneClk   = {tbiClkOdd, tbiClkEven};
  assign codeGroup = {rxErr, rxDv, rxD};

  for (genvar g = 0; g < 2; g++) begin : gLane
    assign lanePop[g] = strobe.emitTbi && (strobe.tbiOdd == (g == 1));
    rx_tbi_lane #(.AW(LANE_AW), .W(CG_W), .SYNC(PTR_SYNC)) u_lane (
      .wrClk (laneClk[g]),
      .clk   (clk),
      .rstN  (rstN),
      .wrEn  (modeE == MODE_TBI),
      .wrData(codeGroup),
      .pop   (lanePop[g]),
      .rdData(laneData[g]),
      .count (laneCnt[g])
    );
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lowNib <= '0;
      lowErr <= 1'b0;
    end else if (strobe.loadLow) begin
      lowNib <= rxD[NIB_W-1:0];
      lowErr <= rxErr;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      outValid   <= 1'b0;
      outData    <= '0;
      outErr     <= 1'b0;
      outDribble <= 1'b0;
      outSlip    <= 1'b0;
    end else begin
      outValid   <= 1'b0;
      outData    <= '0;
      outErr     <= 1'b0;
      outDribble <= 1'b0;
      outSlip    <= 1'b0;
      if (strobe.emitByte) begin
        outValid <= 1'b1;
        outData  <= CG_W'(rxD);
        outErr   <= rxErr;
      end else if (strobe.emitPair) begin
        outValid <= 1'b1;
        outData  <= CG_W'({rxD[NIB_W-1:0], lowNib});
        outErr   <= lowErr | rxErr;
      end else if (strobe.emitPartial) begin
        outValid   <= 1'b1;
        outData    <= CG_W'(lowNib);
        outErr     <= lowErr;
        outDribble <= 1'b1;
      end else if (strobe.emitTbi) begin
        outValid <= 1'b1;
        outData  <= laneData[strobe.tbiOdd];
        outSlip  <= strobe.slip;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) colQ <= '0;
    else       colQ <= {colQ[COL_SYNC-2:0], colIn};
  end

  assign colOut = colQ[COL_SYNC-1] && !fullDuplex && (modeE != MODE_TBI);

endmodule

// File: rtl/rx_phy_capture.sv
module rx_phy_capture
  import rx_capture_pkg::*;
#(
  parameter int LANE_AW  = 2,
  parameter int PTR_SYNC = 2,
  parameter int COL_SYNC = 2
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic [1:0]  mode,
  input  logic        fullDuplex,
  input  logic [7:0]  rxD,
  input  logic        rxDv,
  input  logic        rxErr,
  input  logic        tbiClkEven,
  input  logic        tbiClkOdd,
  input  logic        colIn,
  output logic        outValid,
  output logic [9:0]  outData,
  output logic        outErr,
  output logic        outDribble,
  output logic        outSlip,
  output logic        colOut
);

  localparam int PW = LANE_AW + 1;

  rxMode_t             modeE;
  rxStrobe_t           strobe;
  logic [1:0][PW-1:0]  laneCnt;

  assign modeE = rxMode_t'(mode);

  rx_capture_ctrl #(.PW(PW)) u_ctrl (
    .clk    (clk),
    .rstN   (rstN),
    .modeE  (modeE),
    .rxDv   (rxDv),
    .laneCnt(laneCnt),
    .strobe (strobe)
  );

  rx_capture_dp #(.LANE_AW(LANE_AW), .PTR_SYNC(PTR_SYNC), .COL_SYNC(COL_SYNC)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .modeE     (modeE),
    .fullDuplex(fullDuplex),
    .rxD       (rxD),
    .rxDv      (rxDv),
    .rxErr     (rxErr),
    .tbiClkEven(tbiClkEven),
    .tbiClkOdd (tbiClkOdd),
    .colIn     (colIn),
    .strobe    (strobe),
    .laneCnt   (laneCnt),
    .outValid  (outValid),
    .outData   (outData),
    .outErr    (outErr),
    .outDribble(outDribble),
    .outSlip   (outSlip),
    .colOut    (colOut)
  );

endmodule

// File: rtl/rx_phy_capture_chk.sv
module rx_phy_capture_chk (
  input logic       clk,
  input logic       rstN,
  input logic [1:0] mode,
  input logic       fullDuplex,
  input logic       rxDv,
  input logic       outValid,
  input logic [9:0] outData,
  input logic       outDribble,
  input logic       outSlip,
  input logic       colOut
);

  AST_BYTE_NEXT_EDGE: assert property (@(posedge clk) disable iff (!rstN)
    (mode == 2'b01 && rxDv) |=> outValid); // R2

  AST_NIB_NO_BACK_TO_BACK: assert property (@(posedge clk) disable iff (!rstN)
    (mode == 2'b00 && outValid) |=> !(outValid && mode == 2'b00)); // R3

  AST_DRIBBLE_SHAPE: assert property (@(posedge clk) disable iff (!rstN)
    outDribble |-> (outValid && outData[9:4] == 6'd0 && $past(mode) == 2'b00)); // R5

  AST_SLIP_ONLY_TBI: assert property (@(posedge clk) disable iff (!rstN)
    outSlip |-> (outValid && $past(mode) == 2'b10)); // R7

  AST_COL_MASKED: assert property (@(posedge clk) disable iff (!rstN)
    (fullDuplex || mode == 2'b10) |-> !colOut); // R9

  AST_IDLE_SILENT: assert property (@(posedge clk) disable iff (!rstN)
    ($past(mode) == 2'b11) |-> !outValid); // R10

endmodule

bind rx_phy_capture rx_phy_capture_chk u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .mode      (mode),
  .fullDuplex(fullDuplex),
  .rxDv      (rxDv),
  .outValid  (outValid),
  .outData   (outData),
  .outDribble(outDribble),
  .outSlip   (outSlip),
  .colOut    (colOut)
);

// File: tb/rx_phy_capture_bench.sv
`timescale 1ns/1ps
module rx_phy_capture_bench;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [1:0] mode = 2'b01;
  logic       fullDuplex = 1'b0;
  logic [7:0] rxD = 8'h00;
  logic       rxDv = 1'b0;
  logic       rxErr = 1'b0;
  logic       tbiClkEven = 1'b0;
  logic       tbiClkOdd = 1'b0;
  logic       colIn = 1'b0;
  logic       outValid;
  logic [9:0] outData;
  logic       outErr;
  logic       outDribble;
  logic       outSlip;
  logic       colOut;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  logic [9:0] capData [32];
  logic       capSlip [32];
  int         capN = 0;
  bit         capEn = 1'b0;

  always #4 clk = ~clk;

  rx_phy_capture u_rx_phy_capture (
    .clk(clk), .rstN(rstN), .mode(mode), .fullDuplex(fullDuplex),
    .rxD(rxD), .rxDv(rxDv), .rxErr(rxErr),
    .tbiClkEven(tbiClkEven), .tbiClkOdd(tbiClkOdd), .colIn(colIn),
    .outValid(outValid), .outData(outData), .outErr(outErr),
    .outDribble(outDribble), .outSlip(outSlip), .colOut(colOut)
  );

  // {dv, er, d[7:0], expValid, expErr, expData[9:0]}
  localparam logic [21:0] BYTE_VEC [8] = '{
    {1'b1, 1'b0, 8'h55, 1'b1, 1'b0, 10'h055},
    {1'b1, 1'b0, 8'hAA, 1'b1, 1'b0, 10'h0AA},
    {1'b1, 1'b1, 8'h3C, 1'b1, 1'b1, 10'h03C},
    {1'b0, 1'b0, 8'hFF, 1'b0, 1'b0, 10'h000},
    {1'b0, 1'b1, 8'h12, 1'b0, 1'b0, 10'h000},
    {1'b1, 1'b0, 8'h00, 1'b1, 1'b0, 10'h000},
    {1'b1, 1'b0, 8'hFF, 1'b1, 1'b0, 10'h0FF},
    {1'b0, 1'b0, 8'h00, 1'b0, 1'b0, 10'h000}
  };

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic step(input logic dv, input logic er, input logic [7:0] d);
    @(negedge clk);
    rxDv = dv; rxErr = er; rxD = d;
    @(posedge clk);
    #1;
  endtask

  task automatic applyGroup(input logic [9:0] g);
    {rxErr, rxDv, rxD} = g;
  endtask

  task automatic tbiPair(input logic [9:0] ge, input logic [9:0] go);
    applyGroup(ge);
    #4 tbiClkEven = 1'b1; tbiClkOdd = 1'b0;
    #4 applyGroup(go);
    #4 tbiClkOdd = 1'b1; tbiClkEven = 1'b0;
    #4;
  endtask

  task automatic oddOnly(input logic [9:0] g);
    tbiClkOdd = 1'b0;
    #4 applyGroup(g);
    #4 tbiClkOdd = 1'b1;
    #8;
  endtask

  function automatic logic [9:0] grp(input int k);
    return 10'((k * 149 + 37) ^ (k << 7));
  endfunction

  initial begin
    forever begin
      @(negedge clk);
      if (capEn && outValid && capN < 32) begin
        capData[capN] = outData;
        capSlip[capN] = outSlip;
        capN++;
      end
    end
  end

  initial begin
    #(200000 * 8);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog: actual %0h expected %0h", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    // R1 reset state
    repeat (3) @(posedge clk);
    #1;
    chk(outValid == 0 && outErr == 0, "R1 held reset", {outValid, outErr}, 0);
    @(negedge clk); rstN = 1'b1;
    @(posedge clk); #1;
    chk(outValid == 0, "R1 outValid", outValid, 0);
    chk(outErr == 0 && outDribble == 0, "R1 err/dribble", {outErr, outDribble}, 0);
    chk(outSlip == 0, "R1 outSlip", outSlip, 0);
    chk(colOut == 0, "R1 colOut", colOut, 0);

    // R2 8-bit mode vector table
    for (int i = 0; i < 8; i++) begin
      logic [21:0] v;
      v = BYTE_VEC[i];
      step(v[21], v[20], v[19:12]);
      chk(outValid == v[11], "R2 valid", outValid, v[11]);
      chk(outErr == v[10], "R2 err", outErr, v[10]);
      chk(outData == v[9:0], "R2 data", outData, v[9:0]);
    end

    // R3 nibble pairing, high input bits ignored
    @(negedge clk); mode = 2'b00;
    step(1'b1, 1'b0, 8'h5A);
    chk(outValid == 0, "R3 first nibble silent", outValid, 0);
    step(1'b1, 1'b0, 8'hC3);
    chk(outValid == 1 && outData == 10'h03A, "R3 pair", outData, 10'h03A);
    chk(outErr == 0, "R3 pair no err", outErr, 0);
    // R4 error on first nibble carried into the byte
    step(1'b1, 1'b1, 8'h01);
    chk(outValid == 0, "R4 first nibble silent", outValid, 0);
    step(1'b1, 1'b0, 8'h02);
    chk(outValid == 1 && outData == 10'h021, "R4 pair data", outData, 10'h021);
    chk(outErr == 1, "R4 err carried", outErr, 1);
    // R5 dribble
    step(1'b1, 1'b0, 8'hF7);
    chk(outValid == 0, "R5 held nibble silent", outValid, 0);
    step(1'b0, 1'b0, 8'h00);
    chk(outValid == 1 && outData == 10'h007, "R5 partial data", outData, 10'h007);
    chk(outDribble == 1 && outErr == 0, "R5 dribble flag", {outDribble, outErr}, 2);
    step(1'b0, 1'b0, 8'h00);
    chk(outValid == 0 && outDribble == 0, "R5 single strobe", {outValid, outDribble}, 0);

    // R10 idle mode
    @(negedge clk); mode = 2'b11;
    for (int i = 0; i < 3; i++) begin
      step(1'b1, 1'b1, 8'h99);
      chk(outValid == 0, "R10 idle", outValid, 0);
    end
    step(1'b0, 1'b0, 8'h00);

    // R8 collision two-edge latency
    @(negedge clk); mode = 2'b00; fullDuplex = 1'b0; colIn = 1'b1;
    @(posedge clk); #1;
    chk(colOut == 0, "R8 one edge", colOut, 0);
    @(posedge clk); #1;
    chk(colOut == 1, "R8 two edges", colOut, 1);
    // R9 masking
    @(negedge clk); fullDuplex = 1'b1; #1;
    chk(colOut == 0, "R9 full duplex", colOut, 0);
    @(negedge clk); fullDuplex = 1'b0; mode = 2'b10; #1;
    chk(colOut == 0, "R9 10-bit mode", colOut, 0);
    @(negedge clk); mode = 2'b00; #1;
    chk(colOut == 1, "R8 unmasked", colOut, 1);
    @(negedge clk); colIn = 1'b0;
    @(posedge clk); #1;
    chk(colOut == 1, "R8 fall one edge", colOut, 1);
    @(posedge clk); #1;
    chk(colOut == 0, "R8 fall two edges", colOut, 0);

    // R6 10-bit interleave
    @(negedge clk); rstN = 1'b0;
    @(negedge clk); rstN = 1'b1; mode = 2'b10;
    capN = 0; capEn = 1'b1;
    #3;
    for (int k = 0; k < 6; k += 2) tbiPair(grp(k), grp(k + 1));
    repeat (10) @(posedge clk);
    #1;
    chk(capN == 6, "R6 group count", capN, 6);
    for (int k = 0; k < 6; k++) begin
      chk(capData[k] == grp(k), "R6 order", capData[k], grp(k));
      chk(capSlip[k] == 0, "R6 no slip", capSlip[k], 0);
    end

    // R7 even phase stops: odd groups taken out of turn
    capN = 0;
    oddOnly(10'h2A5);
    oddOnly(10'h15A);
    oddOnly(10'h3C3);
    repeat (10) @(posedge clk);
    #1;
    chk(capN == 2, "R7 slip count", capN, 2);
    chk(capData[0] == 10'h2A5 && capSlip[0] == 1, "R7 first slip", capData[0], 10'h2A5);
    chk(capData[1] == 10'h15A && capSlip[1] == 1, "R7 second slip", capData[1], 10'h15A);
    capEn = 1'b0;

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule